// File: doc/BRIEF.md
# Masked Chip-Select Address Decoder

This block decides which of several programmable address windows an incoming bus request falls into. Each window holds a 16-bit base value compared against the top 16 bits of the request address. It also holds a 16-bit per-bit ignore mask, an enable bit and a write-protect bit. A bit set in the ignore mask removes that address bit from the comparison. This allows windows of any power-of-two size, and also windows with holes or repeated images.

Each request strobe produces one registered response one cycle later, in one of three forms:
- a one-hot chip-select for the winning window;
- a no-match flag when no enabled window covers the address;
- a bus-error flag when a write lands in a protected window.

When several windows overlap, the lowest-numbered one wins. A protected write starts no external cycle, so no chip-select is raised for it. Reads to a protected window proceed normally.

Software programs the windows through a small register port. The port selects a window index and one of two registers per window: the base register or the control/mask register. Reading back through the same selection returns the stored fields, with the unused bits reading as zero.

Top module: `csdec_top`

## Requirements
- R1: After reset every window register reads zero, every window is disabled, and a request produces the no-match response.
- R2: The base register (register kind 0) stores bits 31:16 of the written word. Its bits 15:0 always read zero.
- R3: The control/mask register (register kind 1) stores three fields: the enable bit at bit 0, the write-protect bit at bit 8, and the ignore mask at bits 31:16. Every other bit reads zero.
- R4: An enabled window hits when, for every address bit 31:16 whose ignore-mask bit is 0, the address bit equals the base bit. Address bits 15:0 never affect the decode.
- R5: A window whose enable bit is 0 never hits, whatever its base and mask.
- R6: When several enabled windows hit, only the lowest-numbered one is selected, so the chip-select output is one-hot or all zero.
- R7: A request that hits no enabled window raises the no-match flag for exactly one cycle and drives no chip-select.
- R8: A write whose winning window has write-protect set raises the bus-error flag and no chip-select. A read to the same window selects it normally without an error.
- R9: Responses appear in the cycle after the request strobe is sampled and last one cycle. With no request, all three outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_win | input | IW ($clog2(NUM_WIN)) | Window index for register write and read-back |
| cfg_kind | input | 1 | Register selector: 0 base, 1 control/mask |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read-back of the selected register (combinational) |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | 1 for a write request, 0 for a read |
| cs_sel | output | NUM_WIN | One-hot chip-select of the winning window |
| no_match | output | 1 | Request hit no enabled window |
| bus_err | output | 1 | Write to a protected window |

## Verification
The bench builds the block with its default of five windows and a 32-bit address. This is small enough to sweep every value of the compared high field across two 256- and 512-entry regions, for both reads and writes.

Each region is set up to exercise a specific kind of overlap:
- a nested pair, where a small window lies inside a larger protected one;
- a non-contiguous ignore mask;
- a disabled window that would otherwise hit;
- a protected window shadowed by an unprotected lower-numbered one.

A second configuration adds a catch-all window to show that lower-numbered windows keep priority and that no request then goes unmatched.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned HI_W      = 16;
  localparam int unsigned HI_LSB    = WORD_W - HI_W;
  localparam int unsigned EN_POS    = 0;
  localparam int unsigned PROT_POS  = 8;

  typedef struct packed {
    logic [HI_W-1:0] base;
    logic [HI_W-1:0] ignore;
    logic            en;
    logic            prot;
  } win_cfg_t;
endpackage

// File: rtl/csdec_win_reg.sv
module csdec_win_reg
  import csdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_base,
  input  logic              wr_ctrl,
  input  logic [WORD_W-1:0] wdata,
  output win_cfg_t          cfg
);
  win_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_base) begin
      cfg_d.base = wdata[HI_LSB +: HI_W];
    end
    if (wr_ctrl) begin
      cfg_d.ignore = wdata[HI_LSB +: HI_W];
      cfg_d.en     = wdata[EN_POS];
      cfg_d.prot   = wdata[PROT_POS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_base || wr_ctrl) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/csdec_win_match.sv
module csdec_win_match
  import csdec_pkg::*;
(
  input  win_cfg_t        cfg,
  input  logic [HI_W-1:0] addr_hi,
  output logic            hit
);
  logic [HI_W-1:0] diff;

  assign diff = (addr_hi ^ cfg.base) & ~cfg.ignore;
  assign hit  = cfg.en && (diff == '0);
endmodule

// File: rtl/csdec_prio.sv
module csdec_prio #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  // isolate the lowest set bit: lowest index wins
  assign grant = req & (~req + N'(1));
endmodule

// File: rtl/csdec_top.sv
module csdec_top
  import csdec_pkg::*;
#(
  parameter  int unsigned NUM_WIN = 5,
  localparam int unsigned IW      = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IW-1:0]      cfg_win,
  input  logic               cfg_kind,
  input  logic [WORD_W-1:0]  cfg_wdata,
  output logic [WORD_W-1:0]  cfg_rdata,
  input  logic               req_valid,
  input  logic [WORD_W-1:0]  req_addr,
  input  logic               req_write,
  output logic [NUM_WIN-1:0] cs_sel,
  output logic               no_match,
  output logic               bus_err
);
  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  win_cfg_t           wcfg [NUM_WIN];
  logic [NUM_WIN-1:0] hit_vec;
  logic [NUM_WIN-1:0] prot_vec;
  logic [NUM_WIN-1:0] grant;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    logic sel_here;
    assign sel_here = cfg_we && (cfg_win == IW'(i));

    csdec_win_reg u_reg (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .wr_base (sel_here && !cfg_kind),
      .wr_ctrl (sel_here &&  cfg_kind),
      .wdata   (cfg_wdata),
      .cfg     (wcfg[i])
    );

    csdec_win_match u_match (
      .cfg     (wcfg[i]),
      .addr_hi (req_addr[HI_LSB +: HI_W]),
      .hit     (hit_vec[i])
    );

    assign prot_vec[i] = wcfg[i].prot;
  end

  csdec_prio #(.N(NUM_WIN)) u_prio (
    .req   (hit_vec),
    .grant (grant)
  );

  // register read-back
  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (cfg_win == IW'(i)) begin
        if (cfg_kind) begin
          cfg_rdata[HI_LSB +: HI_W] = wcfg[i].ignore;
          cfg_rdata[PROT_POS]       = wcfg[i].prot;
          cfg_rdata[EN_POS]         = wcfg[i].en;
        end else begin
          cfg_rdata[HI_LSB +: HI_W] = wcfg[i].base;
        end
      end
    end
  end

  // response next state
  logic               winner_prot;
  logic               blocked;
  logic [NUM_WIN-1:0] cs_d;
  logic               miss_d;
  logic               err_d;

  always_comb begin
    winner_prot = |(grant & prot_vec);
    blocked     = req_write && winner_prot;
    cs_d        = (req_valid && !blocked) ? grant : '0;
    miss_d      = req_valid && (hit_vec == '0);
    err_d       = req_valid && blocked;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      cs_sel   <= '0;
      no_match <= 1'b0;
      bus_err  <= 1'b0;
    end else begin
      cs_sel   <= cs_d;
      no_match <= miss_d;
      bus_err  <= err_d;
    end
  end
endmodule

// File: rtl/csdec_chk.sv
module csdec_chk #(
  parameter int unsigned NUM_WIN = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [NUM_WIN-1:0] cs_sel,
  input logic               no_match,
  input logic               bus_err
);
  // R6
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_sel));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (cs_sel == '0) && !no_match && !bus_err);

  // R7
  one_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> $onehot({|cs_sel, no_match, bus_err}));

  // R8
  read_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> !bus_err);
endmodule

bind csdec_top csdec_chk #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .cs_sel    (cs_sel),
  .no_match  (no_match),
  .bus_err   (bus_err)
);

// File: tb/csdec_top_test.sv
`timescale 1ns/1ps
module csdec_top_test;
  localparam int NW = 5;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_we;
  logic [IW-1:0] cfg_win;
  logic          cfg_kind;
  logic [31:0]   cfg_wdata;
  logic [31:0]   cfg_rdata;
  logic          req_valid;
  logic [31:0]   req_addr;
  logic          req_write;
  logic [NW-1:0] cs_sel;
  logic          no_match;
  logic          bus_err;

  always #4 clk = ~clk;

  csdec_top #(.NUM_WIN(NW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win),
    .cfg_kind(cfg_kind), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .cs_sel(cs_sel), .no_match(no_match), .bus_err(bus_err)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // bench-side record of what was programmed
  logic [15:0] sh_base [NW];
  logic [15:0] sh_ign  [NW];
  logic        sh_en   [NW];
  logic        sh_prot [NW];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input int w, input bit kind, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_win = IW'(w); cfg_kind = kind; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (w < NW) begin
      if (!kind) sh_base[w] = d[31:16];
      else begin
        sh_ign[w] = d[31:16]; sh_en[w] = d[0]; sh_prot[w] = d[8];
      end
    end
  endtask

  task automatic rd_chk(input int w, input bit kind, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_win = IW'(w); cfg_kind = kind;
    #1;
    chk(tag, 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic model(input logic [15:0] a, input bit wr,
                       output logic [NW-1:0] cs, output logic miss,
                       output logic err, output string tag);
    int first = -1; int cnt = 0; bit inv_would = 1'b0;
    for (int i = NW-1; i >= 0; i--) begin
      bit m = (((a ^ sh_base[i]) & ~sh_ign[i]) == 16'h0);
      if (m && sh_en[i]) begin first = i; cnt++; end
      if (m && !sh_en[i]) inv_would = 1'b1;
    end
    miss = (first < 0);
    err  = !miss && wr && sh_prot[first];
    cs   = (!miss && !err) ? NW'(1) << first : '0;
    if (!miss && sh_prot[first]) tag = "R8";
    else if (miss && inv_would)  tag = "R5";
    else if (miss)               tag = "R7";
    else if (cnt > 1)            tag = "R6";
    else                         tag = "R4";
  endtask

  task automatic do_req(input logic [15:0] a, input bit wr);
    logic [NW-1:0] ecs; logic emiss, eerr; string tag;
    model(a, wr, ecs, emiss, eerr, tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = {a, ~a};
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, 64'({ecs, emiss, eerr}), 64'({cs_sel, no_match, bus_err}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_win = '0; cfg_kind = 1'b0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0; req_write = 1'b0;
    for (int i = 0; i < NW; i++) begin
      sh_base[i] = '0; sh_ign[i] = '0; sh_en[i] = 1'b0; sh_prot[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    #1 chk("R1 outputs", 64'({cs_sel, no_match, bus_err}), 64'(0));
    for (int w = 0; w < NW; w++) begin
      rd_chk(w, 1'b0, 32'h0, "R1 base");
      rd_chk(w, 1'b1, 32'h0, "R1 ctrl");
    end
    do_req(16'h0000, 1'b0);
    chk("R1 miss after reset", 64'(no_match), 64'(1));

    // R2 / R3: field storage and zero-reading bits
    for (int w = 0; w < NW; w++) begin
      wr_reg(w, 1'b0, 32'hFFFF_FFFF);
      rd_chk(w, 1'b0, 32'hFFFF_0000, "R2 base bits");
      wr_reg(w, 1'b1, 32'hFFFF_FFFF);
      rd_chk(w, 1'b1, 32'hFFFF_0101, "R3 ctrl bits");
      wr_reg(w, 1'b1, 32'h5A5A_FEFE);
      rd_chk(w, 1'b1, 32'h5A5A_0000, "R3 ctrl clear");
      wr_reg(w, 1'b0, 32'h0000_0000);
      wr_reg(w, 1'b1, 32'h0000_0000);
    end

    // configuration A
    wr_reg(0, 1'b0, 32'h12A0_0000); wr_reg(0, 1'b1, 32'h000F_0001);
    wr_reg(1, 1'b0, 32'h1200_0000); wr_reg(1, 1'b1, 32'h00FF_0101);
    wr_reg(2, 1'b0, 32'h3450_0000); wr_reg(2, 1'b1, 32'h000F_0000);
    wr_reg(3, 1'b0, 32'h3400_0000); wr_reg(3, 1'b1, 32'h0030_0001);
    wr_reg(4, 1'b0, 32'h3400_0000); wr_reg(4, 1'b1, 32'h0101_0101);

    // R9: latency and single-cycle pulse
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h12A5_0000;
    #1 chk("R9 before edge", 64'({cs_sel, no_match, bus_err}), 64'(0));
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 one cycle later", 64'({cs_sel, no_match, bus_err}), 64'({5'b00001, 2'b00}));
    @(negedge clk);
    chk("R9 pulse ends", 64'({cs_sel, no_match, bus_err}), 64'(0));

    // sweeps over the compared field, reads and writes
    for (int a = 16'h1200; a <= 16'h12FF; a++) begin
      do_req(16'(a), 1'b0);
      do_req(16'(a), 1'b1);
    end
    for (int a = 16'h3400; a <= 16'h35FF; a++) begin
      do_req(16'(a), 1'b0);
      do_req(16'(a), 1'b1);
    end

    // configuration B: catch-all window 4, unprotected
    wr_reg(4, 1'b1, 32'hFFFF_0001);
    for (int k = 0; k < 256; k++) begin
      do_req(16'(k * 16'h0101), k[0]);
      chk("R7 catch-all no miss", 64'(no_match), 64'(0));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule